// File: doc/BRIEF.md
# Power-Budgeted Self-Test Session Sequencer

This block drives a set of up to six built-in self-test engines in a series of sessions. Every test has a power weight and a run length in clock cycles. Each session names a group of tests with a bitmask. All tests in a session start together and run at the same time. Sessions run one after another, in index order.

Before it launches a session, the sequencer adds up the power weights of the tests in that session. It compares the total with a programmed ceiling. A session over the ceiling is never launched: the sequencer raises an error flag and halts. A session that fits raises each member's enable line for exactly that test's own length. The session ends when its longest member ends, and the next session is then examined. After the last programmed session the done flag rises. The elapsed counter then holds the summed session durations, which is the number of cycles in which at least one enable was high.

A parent controller programs the tables and pulses start. It then waits for done or error and reads the elapsed count.

Top module: `bist_session_seq`

## Requirements
- R1: After reset, all enables are low, busy, done and error are low, and the elapsed count is zero.
- R2: A session whose summed member power is above `pwr_limit_i` is never launched. Error goes high and stays high, no enable rises, and the sequencer halts. A sum equal to the limit is allowed.
- R3: All members of a session are enabled in the same cycle. Test i's enable (bit i of `test_en_o`) stays high for exactly its length, counted in consecutive cycles, taken from `test_len_i[i*LEN_W +: LEN_W]`. Only tests whose bit is set in the session mask are ever enabled.
- R4: A session lasts as long as its longest member. The elapsed count increases by one in every cycle with any enable high, so it equals the sum of the session durations.
- R5: Sessions 0 to `sess_cnt_i`-1 run in index order. Session s takes its mask from `sess_mask_i[s*NUM_TESTS +: NUM_TESTS]`, and test i's power from `test_pwr_i[i*PWR_W +: PWR_W]`. An all-zero mask is skipped and adds nothing to the elapsed count. Sessions at or above `sess_cnt_i` are not run.
- R6: After the last session, done is high and the elapsed count holds its value until the next start.
- R7: A start pulse while busy is high has no effect on the run in progress.
- R8: A start pulse while idle, done or in error clears the flags and the elapsed count, and the run begins at session 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| test_pwr_i | input | NUM_TESTS*PWR_W | Per-test power weights |
| test_len_i | input | NUM_TESTS*LEN_W | Per-test lengths in cycles |
| sess_mask_i | input | NUM_SESS*NUM_TESTS | Per-session test masks |
| sess_cnt_i | input | SIDX_W | Number of programmed sessions |
| pwr_limit_i | input | SUM_W | Per-session power ceiling |
| test_en_o | output | NUM_TESTS | Per-test enable lines |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | All sessions completed |
| err_o | output | 1 | Halted on an over-budget session |
| elapsed_o | output | CYC_W | Cycles with any test enabled |

## Verification
Several properties are checked on every clock edge:
- The power of the currently enabled tests never exceeds the ceiling.
- Enables appear only for members of the current session, and only while busy.
- The error state holds all enables low, and done and error never coincide.
- The elapsed count is frozen while done.
- A start pulse during a run never resets the count.

Only the bench scenarios can show the totals. These are the exact length of each enable, the session duration being the longest member, the summed elapsed count of a multi-session run, the skipping of empty masks, and the halt with its partial count when a later session is over budget.

// File: rtl/bist_session_seq.sv
module bist_session_seq #(
  parameter int NUM_TESTS = 6,
  parameter int NUM_SESS  = 6,
  parameter int PWR_W     = 4,
  parameter int LEN_W     = 8,
  parameter int CYC_W     = 16,
  localparam int SUM_W    = PWR_W + $clog2(NUM_TESTS + 1),
  localparam int SIDX_W   = $clog2(NUM_SESS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [NUM_TESTS*PWR_W-1:0]    test_pwr_i,
  input  logic [NUM_TESTS*LEN_W-1:0]    test_len_i,
  input  logic [NUM_SESS*NUM_TESTS-1:0] sess_mask_i,
  input  logic [SIDX_W-1:0]             sess_cnt_i,
  input  logic [SUM_W-1:0]              pwr_limit_i,
  output logic [NUM_TESTS-1:0]          test_en_o,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          err_o,
  output logic [CYC_W-1:0]              elapsed_o
);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_RUN, S_DONE, S_ERR} state_t;

  state_t              state;
  logic [SIDX_W-1:0]   sess_idx;
  logic [NUM_TESTS-1:0] cur_mask;
  logic [NUM_TESTS-1:0] near_end;
  logic [SUM_W-1:0]    sess_sum;
  logic [SUM_W-1:0]    live_sum;
  logic                past_last;
  logic                over_budget;
  logic                launch;

  always_comb begin
    cur_mask = '0;
    for (int s = 0; s < NUM_SESS; s++)
      if (sess_idx == SIDX_W'(s)) cur_mask = sess_mask_i[s*NUM_TESTS +: NUM_TESTS];
  end

  always_comb begin
    sess_sum = '0;
    live_sum = '0;
    for (int i = 0; i < NUM_TESTS; i++) begin
      if (cur_mask[i])  sess_sum = sess_sum + SUM_W'(test_pwr_i[i*PWR_W +: PWR_W]);
      if (test_en_o[i]) live_sum = live_sum + SUM_W'(test_pwr_i[i*PWR_W +: PWR_W]);
    end
  end

  assign past_last   = (sess_idx >= sess_cnt_i) || (sess_idx >= SIDX_W'(NUM_SESS));
  assign over_budget = sess_sum > pwr_limit_i;
  assign launch      = (state == S_CHECK) && !past_last && (cur_mask != '0) && !over_budget;

  for (genvar g = 0; g < NUM_TESTS; g++) begin : gen_test
    logic [LEN_W-1:0] rem;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rem <= '0;
      else if (launch)     rem <= cur_mask[g] ? test_len_i[g*LEN_W +: LEN_W] : '0;
      else if (rem != '0)  rem <= rem - 1'b1;
    end
    assign test_en_o[g] = (rem != '0);
    assign near_end[g]  = (rem <= LEN_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sess_idx  <= '0;
      elapsed_o <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE, S_ERR:
          if (start_i) begin
            state     <= S_CHECK;
            sess_idx  <= '0;
            elapsed_o <= '0;
          end
        S_CHECK:
          if (past_last)              state    <= S_DONE;
          else if (cur_mask == '0)    sess_idx <= sess_idx + 1'b1;
          else if (over_budget)       state    <= S_ERR;
          else                        state    <= S_RUN;
        S_RUN: begin
          if (|test_en_o) elapsed_o <= elapsed_o + 1'b1;
          if (&near_end) begin
            state    <= S_CHECK;
            sess_idx <= sess_idx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state == S_CHECK) || (state == S_RUN);
  assign done_o = (state == S_DONE);
  assign err_o  = (state == S_ERR);

  assert_power_budget_R2: assert property (@(posedge clk) disable iff (!rst_n)
    live_sum <= pwr_limit_i);
  assert_err_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (test_en_o == '0));
  assert_en_in_session_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en_o & ~cur_mask) == '0);
  assert_en_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|test_en_o) |-> busy_o);
  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o) && !(busy_o && (done_o || err_o)));
  assert_count_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (elapsed_o == $past(elapsed_o)));
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (elapsed_o == $past(elapsed_o) || elapsed_o == $past(elapsed_o) + 1'b1));

endmodule

// File: tb/tb_bist_session_seq.sv
module tb_bist_session_seq;
  localparam int NT = 6, NS = 6, PW = 4, LW = 8, CW = 16;
  localparam int SW = PW + $clog2(NT + 1);
  localparam int XW = $clog2(NS + 1);

  logic clk = 0, rst_n = 0, start_i = 0;
  logic [NT*PW-1:0] test_pwr_i;
  logic [NT*LW-1:0] test_len_i;
  logic [NS*NT-1:0] sess_mask_i;
  logic [XW-1:0]    sess_cnt_i;
  logic [SW-1:0]    pwr_limit_i;
  logic [NT-1:0]    test_en_o;
  logic busy_o, done_o, err_o;
  logic [CW-1:0]    elapsed_o;

  bist_session_seq #(.NUM_TESTS(NT), .NUM_SESS(NS), .PWR_W(PW), .LEN_W(LW), .CYC_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .test_pwr_i(test_pwr_i),
    .test_len_i(test_len_i), .sess_mask_i(sess_mask_i), .sess_cnt_i(sess_cnt_i),
    .pwr_limit_i(pwr_limit_i), .test_en_o(test_en_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .elapsed_o(elapsed_o));

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0;
  int pw[NT] = '{2, 1, 1, 1, 2, 1};
  int ln[NT] = '{100, 10, 10, 5, 10, 100};
  int masks[NS];
  int limit = 4;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int cnt, input int inject, input string tag);
    int en_cnt[NT];
    int exp_cnt[NT];
    int exp_el = 0, exp_err = 0, peak = 0, n = 0;
    for (int i = 0; i < NT; i++) begin
      en_cnt[i] = 0; exp_cnt[i] = 0;
      test_pwr_i[i*PW +: PW] = PW'(pw[i]);
      test_len_i[i*LW +: LW] = LW'(ln[i]);
    end
    for (int s = 0; s < NS; s++) sess_mask_i[s*NT +: NT] = NT'(masks[s]);
    sess_cnt_i = XW'(cnt);
    pwr_limit_i = SW'(limit);
    for (int s = 0; s < cnt; s++) begin
      int sum = 0, mx = 0;
      if (masks[s] == 0) continue;
      for (int i = 0; i < NT; i++) if (masks[s][i]) begin
        sum += pw[i];
        if (ln[i] > mx) mx = ln[i];
      end
      if (sum > limit) begin exp_err = 1; break; end
      exp_el += mx;
      for (int i = 0; i < NT; i++) if (masks[s][i]) exp_cnt[i] += ln[i];
    end
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    while (!(done_o || err_o) && n < 3000) begin
      int p = 0;
      for (int i = 0; i < NT; i++) if (test_en_o[i]) begin en_cnt[i]++; p += pw[i]; end
      if (p > peak) peak = p;
      n++;
      if (n == inject) start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    check({tag, " R6 done flag"}, int'(done_o), 1 - exp_err);
    check({tag, " R2 error flag"}, int'(err_o), exp_err);
    check({tag, " R4 elapsed"}, int'(elapsed_o), exp_el);
    check({tag, " R2 peak power within limit"}, int'(peak <= limit), 1);
    for (int i = 0; i < NT; i++)
      check({tag, $sformatf(" R3 enable cycles of test %0d", i)}, en_cnt[i], exp_cnt[i]);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) masks[s] = 0;
    test_pwr_i = '0; test_len_i = '0; sess_mask_i = '0; sess_cnt_i = '0; pwr_limit_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 enables after reset", int'(test_en_o), 0);
    check("R1 flags after reset", int'({busy_o, done_o, err_o}), 0);
    check("R1 elapsed after reset", int'(elapsed_o), 0);

    // R2 R3 R4: every single-session mask, with the limit of 4 (sum equal to limit allowed)
    for (int m = 0; m < 64; m++) begin
      masks[0] = m;
      run(1, 0, $sformatf("sweep mask %0d", m));
    end

    // R4 R5 R8: three sessions with an empty one between them, total 10+10+100
    masks[0] = 6'b001100; masks[1] = 0; masks[2] = 6'b010010; masks[3] = 6'b100001;
    run(4, 0, "R5 three sessions");
    check("R4 total of example", int'(elapsed_o), 120);
    repeat (5) @(negedge clk);
    check("R6 elapsed frozen after done", int'(elapsed_o), 120);

    // R7: start pulse in the middle of the long session
    run(4, 60, "R7 start while busy");

    // R5: sessions beyond the programmed count are not run
    run(1, 0, "R5 count limits sessions");
    check("R5 only first session counted", int'(elapsed_o), 10);

    // R2: second session is over budget (power 5), first one completes
    masks[1] = 6'b110001; masks[2] = 0; masks[3] = 0;
    run(2, 0, "R2 over budget later");
    check("R2 partial elapsed at halt", int'(elapsed_o), 10);
    repeat (4) @(negedge clk);
    check("R2 stays halted", int'({err_o, busy_o, |test_en_o}), 4);

    // R8: restart from error clears state
    masks[1] = 0;
    run(2, 0, "R8 restart after error");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule